// File: doc/BRIEF.md
# DMA Write-Channel Status Tracker

This block keeps the status of a stream-to-memory DMA write channel. It has one 32-bit status word that is read and written through a simple register port. The block keeps a count of completed transfers that software has not yet acknowledged. It also counts memory write commands that have been issued but whose write response has not yet come back. It passes through the destination FIFO occupancy and derives a busy flag from a small state machine.

Its inputs are single-cycle pulses for:
- transfer completion,
- write-command issue,
- write-response return,
- interrupt acknowledge.

It also takes the FIFO level, a command-active level and a pipeline-empty level. The busy machine has three states:
- `ST_IDLE`: no work.
- `ST_RUN`: a command is active.
- `ST_DRAIN`: the command has ended but data is still in flight.

The transitions are named as follows:
- `T_START`: IDLE to RUN, on command active.
- `T_LEFTOVER`: IDLE to DRAIN, when data remains with no command.
- `T_FINISH`: RUN to DRAIN, when the command ends with data left.
- `T_QUIT`: RUN to IDLE, when the command ends with everything empty.
- `T_RESTART`: DRAIN to RUN, on a new command.
- `T_DRAINED`: DRAIN to IDLE, once everything is empty.

Status word layout:
- Bits 15:13: unacknowledged completions.
- Bits 12:5: FIFO level.
- Bits 4:1: outstanding writes.
- Bit 0: busy.

Top module: `wch_status_tracker`

## Requirements
- R1: After reset every bit of the status word reads 0. Bits 31:16 always read 0, and writing them has no effect.
- R2: Each completion pulse raises the completion count in bits 15:13 by one. The count saturates at 7.
- R3: Each acknowledge pulse lowers the completion count by one, and has no effect at 0. A completion and an acknowledge in the same cycle leave the count unchanged, except that 7 becomes 6.
- R4: A register write whose bits 15:13 are 3'b111 clears the completion count to 0, even if a completion or acknowledge arrives in the same cycle. Any other value in those bits leaves the count unchanged.
- R5: Bits 12:5 report the FIFO level input in 32-bit words, across the range 0 to 128.
- R6: Bits 4:1 hold the outstanding-write count. It rises on each issue pulse and falls on each response pulse. An issue and a response in the same cycle cause no change.
- R7: Output `wr_err` is high in any cycle where one of these occurs:
  - a response arrives, with no issue, while the outstanding count is 0;
  - an issue arrives, with no response, while the count is 15.
  
  In such a cycle the count holds its value.
- R8: Bit 0 (busy) is the state register of the busy machine; it is 1 in `ST_RUN` and `ST_DRAIN`. The machine returns to `ST_IDLE` one clock after all three of these hold: command-active low, FIFO level 0 and pipeline-empty high. No pause input exists, so no pause control can affect busy.
- R9: A read request captures the status word at the clock edge. `reg_rdata` and `reg_rvalid` present it in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_done | input | 1 | Transfer-completed pulse |
| irq_ack | input | 1 | Completion-acknowledge pulse |
| wr_issue | input | 1 | Write command issued pulse |
| wr_resp | input | 1 | Write response returned pulse |
| fifo_level | input | 8 | Destination FIFO occupancy in words |
| cmd_active | input | 1 | A command is being processed |
| pipe_empty | input | 1 | Downstream pipeline registers empty |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read request |
| reg_rdata | output | 32 | Captured status word |
| reg_rvalid | output | 1 | Read data valid |
| wr_err | output | 1 | Outstanding-count underflow/overflow attempt |

## Verification
The assertions assume the following about the inputs:
- Every event input is a pulse that lasts one cycle.
- `fifo_level` stays within 0 to 128.
- A response is normally preceded by its issue.

The bench drives each pulse for exactly one cycle and keeps the FIFO level inside its range. It steps deliberately past the outstanding-count limits only in the directed error cases, where `wr_err` is expected. Reads are always issued with every event pulse low, so that the captured word is not disturbed by an update at the same edge.

// File: rtl/wch_status_pkg.sv
package wch_status_pkg;
    localparam int DONE_W  = 3;
    localparam int LVL_W   = 8;
    localparam int OUT_W   = 4;
    localparam int BUSY_LSB = 0;
    localparam int OUT_LSB  = BUSY_LSB + 1;
    localparam int LVL_LSB  = OUT_LSB + OUT_W;
    localparam int DONE_LSB = LVL_LSB + LVL_W;
    localparam int USED_W   = DONE_LSB + DONE_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } busy_state_t;
endpackage

// File: rtl/wch_done_counter.sv
module wch_done_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    logic [W-1:0] cnt_nx;

    always_comb begin
        cnt_nx = cnt;
        unique case ({inc, dec})
            2'b10: if (cnt != TOP) cnt_nx = cnt + 1'b1;
            2'b01: if (cnt != '0)  cnt_nx = cnt - 1'b1;
            2'b11: if (cnt == TOP) cnt_nx = cnt - 1'b1;
            default: cnt_nx = cnt;
        endcase
        if (clr) cnt_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nx;
    end
endmodule

// File: rtl/wch_wr_tracker.sv
module wch_wr_tracker #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic         resp,
    output logic [W-1:0] cnt,
    output logic         err
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    logic under, over;

    always_comb begin
        under = resp && !issue && (cnt == '0);
        over  = issue && !resp && (cnt == TOP);
        err   = under || over;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!err) begin
            if (issue && !resp)      cnt <= cnt + 1'b1;
            else if (resp && !issue) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wch_busy_fsm.sv
module wch_busy_fsm
    import wch_status_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_active,
    input  logic          pipe_empty,
    input  logic [LW-1:0] level,
    output busy_state_t   state,
    output logic          busy
);
    busy_state_t state_nx;
    logic drained;

    always_comb begin
        drained  = pipe_empty && (level == '0);
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_active)   state_nx = ST_RUN;     // T_START
                else if (!drained) state_nx = ST_DRAIN;  // T_LEFTOVER
            end
            ST_RUN: begin
                if (!cmd_active) begin
                    if (drained) state_nx = ST_IDLE;     // T_QUIT
                    else         state_nx = ST_DRAIN;    // T_FINISH
                end
            end
            ST_DRAIN: begin
                if (cmd_active)   state_nx = ST_RUN;     // T_RESTART
                else if (drained) state_nx = ST_IDLE;    // T_DRAINED
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb busy = (state != ST_IDLE);
endmodule

// File: rtl/wch_status_tracker.sv
module wch_status_tracker
    import wch_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_done,
    input  logic              irq_ack,
    input  logic              wr_issue,
    input  logic              wr_resp,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              cmd_active,
    input  logic              pipe_empty,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_rd,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              wr_err
);
    logic [DONE_W-1:0] done_cnt;
    logic [OUT_W-1:0]  out_cnt;
    logic              done_clr;
    logic              busy;
    busy_state_t       busy_st;
    logic [31:0]       status_word;

    always_comb done_clr = reg_wr && (reg_wdata[DONE_LSB +: DONE_W] == {DONE_W{1'b1}});

    wch_done_counter #(.W(DONE_W)) u_done (
        .clk(clk), .rst_n(rst_n), .inc(xfer_done), .dec(irq_ack),
        .clr(done_clr), .cnt(done_cnt)
    );

    wch_wr_tracker #(.W(OUT_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .issue(wr_issue), .resp(wr_resp),
        .cnt(out_cnt), .err(wr_err)
    );

    wch_busy_fsm #(.LW(LVL_W)) u_busy (
        .clk(clk), .rst_n(rst_n), .cmd_active(cmd_active), .pipe_empty(pipe_empty),
        .level(fifo_level), .state(busy_st), .busy(busy)
    );

    always_comb begin
        status_word = '0;
        status_word[DONE_LSB +: DONE_W] = done_cnt;
        status_word[LVL_LSB  +: LVL_W]  = fifo_level;
        status_word[OUT_LSB  +: OUT_W]  = out_cnt;
        status_word[BUSY_LSB]           = busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= status_word;
        end
    end
endmodule

// File: rtl/wch_status_checker.sv
module wch_status_checker
    import wch_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_done,
    input logic              irq_ack,
    input logic              wr_issue,
    input logic              wr_resp,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              cmd_active,
    input logic              pipe_empty,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic              reg_rd,
    input logic [31:0]       reg_rdata,
    input logic              reg_rvalid,
    input logic              wr_err,
    input logic [DONE_W-1:0] done_cnt,
    input logic [OUT_W-1:0]  out_cnt,
    input logic              busy
);
    logic clr_w;
    always_comb clr_w = reg_wr && (reg_wdata[15:13] == 3'b111);

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> reg_rdata[31:16] == 16'h0);

    assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !irq_ack && !clr_w && done_cnt == 3'd7) |=> done_cnt == 3'd7);

    assert_ack_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !xfer_done && !clr_w && done_cnt != 3'd0) |=> done_cnt == $past(done_cnt) - 3'd1);

    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> done_cnt == 3'd0);

    assert_net_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_issue && wr_resp) |=> $stable(out_cnt));

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> $stable(out_cnt));

    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_active && fifo_level == '0 && pipe_empty) |=> !busy);

    assert_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
endmodule

bind wch_status_tracker wch_status_checker u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .irq_ack(irq_ack),
    .wr_issue(wr_issue), .wr_resp(wr_resp), .fifo_level(fifo_level),
    .cmd_active(cmd_active), .pipe_empty(pipe_empty), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .wr_err(wr_err), .done_cnt(done_cnt),
    .out_cnt(out_cnt), .busy(busy)
);

// File: tb/wch_status_tracker_test.sv
module wch_status_tracker_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_done = 0, irq_ack = 0, wr_issue = 0, wr_resp = 0;
    logic [7:0] fifo_level = 8'd0;
    logic cmd_active = 0, pipe_empty = 1;
    logic reg_wr = 0, reg_rd = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic reg_rvalid, wr_err;

    int checks = 0, fails = 0;
    logic finished = 0;

    always #2 clk = ~clk;

    wch_status_tracker uut (.*);

    // {done, ack, issue, resp, clear_write, exp_done[2:0], exp_out[3:0]}
    localparam logic [11:0] VEC [14] = '{
        {5'b10100, 3'd1, 4'd1},
        {5'b10100, 3'd2, 4'd2},
        {5'b11110, 3'd2, 4'd2},
        {5'b01010, 3'd1, 4'd1},
        {5'b10000, 3'd2, 4'd1},
        {5'b10100, 3'd3, 4'd2},
        {5'b10100, 3'd4, 4'd3},
        {5'b10100, 3'd5, 4'd4},
        {5'b10100, 3'd6, 4'd5},
        {5'b10100, 3'd7, 4'd6},
        {5'b10100, 3'd7, 4'd7},
        {5'b11000, 3'd6, 4'd7},
        {5'b10001, 3'd0, 4'd7},
        {5'b01010, 3'd0, 4'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(output logic [31:0] d);
        @(negedge clk) reg_rd = 1'b1;
        @(negedge clk) reg_rd = 1'b0;
        check("R9 rvalid", {31'd0, reg_rvalid}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk) begin reg_wr = 1'b1; reg_wdata = v; end
        @(negedge clk) begin reg_wr = 1'b0; reg_wdata = '0; end
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(d);
        check("R1 reset word", d, 32'h0);

        foreach (VEC[i]) begin
            @(negedge clk) begin
                {xfer_done, irq_ack, wr_issue, wr_resp} = VEC[i][11:8];
                reg_wr = VEC[i][7];
                reg_wdata = VEC[i][7] ? 32'h0000_E000 : 32'h0;
            end
            @(negedge clk) begin
                {xfer_done, irq_ack, wr_issue, wr_resp, reg_wr} = '0;
                reg_wdata = '0;
            end
            rd(d);
            check("R2/R3/R4 done count", {29'd0, d[15:13]}, {29'd0, VEC[i][6:4]});
            check("R6 outstanding", {28'd0, d[4:1]}, {28'd0, VEC[i][3:0]});
        end

        // R4/R1: non-clearing value plus ones in upper bits
        @(negedge clk) xfer_done = 1'b1;
        @(negedge clk) xfer_done = 1'b0;
        wr(32'hFFFF_5FFF);
        rd(d);
        check("R4 no clear on 010", {29'd0, d[15:13]}, 32'd1);
        check("R1 upper zero", {16'd0, d[31:16]}, 32'd0);

        // R7: overflow at 15
        repeat (9) begin
            @(negedge clk) wr_issue = 1'b1;
        end
        @(negedge clk) wr_issue = 1'b1;
        #1 check("R7 overflow err", {31'd0, wr_err}, 32'd1);
        @(negedge clk) wr_issue = 1'b0;
        rd(d);
        check("R7 held at 15", {28'd0, d[4:1]}, 32'd15);
        repeat (15) begin
            @(negedge clk) wr_resp = 1'b1;
        end
        @(negedge clk) wr_resp = 1'b1;
        #1 check("R7 underflow err", {31'd0, wr_err}, 32'd1);
        @(negedge clk) wr_resp = 1'b0;
        #1 check("R7 err clear", {31'd0, wr_err}, 32'd0);
        rd(d);
        check("R7 held at 0", {28'd0, d[4:1]}, 32'd0);

        // R5: level field
        @(negedge clk) fifo_level = 8'd128;
        rd(d);
        check("R5 level 128", {24'd0, d[12:5]}, 32'h80);
        check("R8 leftover busy", {31'd0, d[0]}, 32'd1);
        @(negedge clk) fifo_level = 8'd0;
        step();
        rd(d);
        check("R8 drained idle", {31'd0, d[0]}, 32'd0);

        // R8: busy machine
        @(negedge clk) cmd_active = 1'b1;
        step();
        rd(d);
        check("R8 run busy", {31'd0, d[0]}, 32'd1);
        @(negedge clk) begin cmd_active = 1'b0; fifo_level = 8'd5; end
        step();
        rd(d);
        check("R8 drain busy", {31'd0, d[0]}, 32'd1);
        check("R5 level 5", {24'd0, d[12:5]}, 32'd5);
        @(negedge clk) begin fifo_level = 8'd0; pipe_empty = 1'b0; end
        step();
        rd(d);
        check("R8 pipe busy", {31'd0, d[0]}, 32'd1);
        @(negedge clk) pipe_empty = 1'b1;
        step();
        rd(d);
        check("R8 idle", {31'd0, d[0]}, 32'd0);

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule